// File: doc/BRIEF.md
# Quadrature Position Counter with Scan-Gated Clear and Target Table

This block keeps a signed position count driven by a pair of quadrature phase inputs, decoded at four counts per phase cycle after two-flop input synchronization. A host that works in scan cycles presents a clear request bit and a one-clock scan strobe. The request bit is looked at only on the strobe, so a request that is shorter than one scan period can be missed.

The count can be cleared in one of two ways, picked by a mode input. In direct mode a request seen on the strobe clears the count at once. In index mode a request seen on the strobe arms the clear, and the first rising edge of the index input after that clears the count. A table of target values is loaded through a simple write port. It is walked one entry per clock, and a match raises a one-cycle interrupt that carries the entry number. Clearing the count never touches the table or the compare enable.

Top module: `quad_pos_counter`

## Requirements
- R1: While rst_n is low, and for two rising clock edges after it is released, count is 0, phase_err is 0 and hit_irq is 0.
- R2: The phase position code of {quad_a, quad_b} runs 00, 01, 11, 10 and back to 00. One step forward in this order adds 1 to count and one step backward subtracts 1. A change becomes visible on count just after the third rising edge, counting the edge that first samples the new input level.
- R3: A change of both phases in one sample (a jump of two positions) leaves count unchanged and sets phase_err, which stays 1 until reset.
- R4: With clr_mode = 0 (direct), count becomes 0 at the rising edge where scan_tick and clr_req are both 1. While scan_tick is 0, clr_req has no effect.
- R5: With clr_mode = 1 (index), a scan_tick with clr_req = 1 arms a clear. The first synchronized rising edge of quad_z after that clears count and disarms, so a later quad_z edge does not clear count.
- R6: With clr_mode = 1, a quad_z rising edge while not armed leaves count unchanged. A scan_tick with clr_req = 0 disarms a pending clear.
- R7: When a clear and a count step fall on the same clock edge, count becomes 0 and the step is dropped.
- R8: The table holds 48 entries of 32 bits. An entry is written at a rising edge with tbl_we = 1, and an address of 48 or more is ignored. Entries 0 to tbl_used-1 are examined round-robin, one per clock, with tbl_used capped at 48. When cmp_en = 1 and the examined entry equals count, hit_irq is 1 for one cycle and hit_idx shows that entry number.
- R9: After an entry has produced a hit, it does not hit again until count changes value.
- R10: Clearing count leaves the table contents and cmp_en as they were. An entry equal to 0 hits after the clear, and entries matching later counts still hit.
- R11: While cmp_en = 0, hit_irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| quad_a | input | 1 | Quadrature phase A, asynchronous |
| quad_b | input | 1 | Quadrature phase B, asynchronous |
| quad_z | input | 1 | Index pulse, asynchronous |
| scan_tick | input | 1 | One-clock strobe marking the host scan point |
| clr_req | input | 1 | Clear request bit from the host |
| clr_mode | input | 1 | 0 = direct clear, 1 = index-gated clear |
| cmp_en | input | 1 | Target comparison enable |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table write address |
| tbl_data | input | 32 | Table write value |
| tbl_used | input | 6 | Number of table entries examined |
| count | output | 32 | Signed position count |
| phase_err | output | 1 | Sticky illegal-transition flag |
| hit_irq | output | 1 | One-cycle target match pulse |
| hit_idx | output | 6 | Entry number of the latest match |

## Verification
Two pairs of functions can fall on the same clock edge. A count step can land on the edge where a direct clear takes effect. The bench provokes this by driving a phase step two edges ahead of the strobe, so that it leaves the synchronizer on the clearing edge, and it then expects zero with no later step. A clear can also meet the table scan: clearing to zero with an entry holding zero has to produce a hit even though the count has just moved. A behavioural reference model predicts count, the flag and every interrupt on every clock, so any overlap that the directed sequence does not reach is still compared.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic {
    CLR_DIRECT = 1'b0,
    CLR_INDEX  = 1'b1
  } clr_mode_e;

  // Gray phase pair to a 2-bit position that rises in the forward direction.
  function automatic logic [1:0] phase_pos(input logic a, input logic b);
    return {a, a ^ b};
  endfunction

endpackage

// File: rtl/qpc_rst_sync.sv
module qpc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/qpc_quad_front.sv
module qpc_quad_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_in,
  input  logic b_in,
  input  logic z_in,
  output logic step_up,
  output logic step_dn,
  output logic step_bad,
  output logic z_rise
);
  import qpc_pkg::*;

  logic [SYNC_STAGES-1:0] a_sh_q, b_sh_q, z_sh_q;
  logic [SYNC_STAGES-1:0] a_sh_d, b_sh_d, z_sh_d;
  logic a_p_q, b_p_q, z_p_q;
  logic a_s, b_s, z_s;
  logic [1:0] pos_now, pos_old, delta;

  if (SYNC_STAGES > 1) begin : g_chain
    assign a_sh_d = {a_sh_q[SYNC_STAGES-2:0], a_in};
    assign b_sh_d = {b_sh_q[SYNC_STAGES-2:0], b_in};
    assign z_sh_d = {z_sh_q[SYNC_STAGES-2:0], z_in};
  end else begin : g_single
    assign a_sh_d = a_in;
    assign b_sh_d = b_in;
    assign z_sh_d = z_in;
  end

  assign a_s = a_sh_q[SYNC_STAGES-1];
  assign b_s = b_sh_q[SYNC_STAGES-1];
  assign z_s = z_sh_q[SYNC_STAGES-1];

  always_comb begin
    pos_now  = phase_pos(a_s, b_s);
    pos_old  = phase_pos(a_p_q, b_p_q);
    delta    = pos_now - pos_old;
    step_up  = (delta == 2'd1);
    step_dn  = (delta == 2'd3);
    step_bad = (delta == 2'd2);
    z_rise   = z_s & ~z_p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh_q <= '0;
      b_sh_q <= '0;
      z_sh_q <= '0;
      a_p_q  <= 1'b0;
      b_p_q  <= 1'b0;
      z_p_q  <= 1'b0;
    end else begin
      a_sh_q <= a_sh_d;
      b_sh_q <= b_sh_d;
      z_sh_q <= z_sh_d;
      a_p_q  <= a_s;
      b_p_q  <= b_s;
      z_p_q  <= z_s;
    end
  end
endmodule

// File: rtl/qpc_clear_ctrl.sv
module qpc_clear_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_tick,
  input  logic clr_req,
  input  logic clr_mode,
  input  logic z_rise,
  output logic clr_fire
);
  import qpc_pkg::*;

  logic arm_q, arm_d;
  logic direct_fire, index_fire;

  always_comb begin
    direct_fire = scan_tick & clr_req & (clr_mode == CLR_DIRECT);
    index_fire  = (clr_mode == CLR_INDEX) & arm_q & z_rise;
    clr_fire    = direct_fire | index_fire;
    arm_d       = arm_q;
    if (scan_tick)       arm_d = clr_req & (clr_mode == CLR_INDEX);
    else if (index_fire) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/qpc_target_cmp.sv
module qpc_target_cmp #(
  parameter int CNT_W = 32,
  parameter int DEPTH = 48,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int NUM_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             count_moved,
  input  logic             cmp_en,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [CNT_W-1:0] tbl_data,
  input  logic [NUM_W-1:0] tbl_used,
  output logic             hit_irq,
  output logic [IDX_W-1:0] hit_idx
);
  localparam int PW = NUM_W + 1;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] ptr_q, ptr_d, idx_q, idx_d;
  logic [DEPTH-1:0] fired_q, fired_d;
  logic             irq_q, irq_d;
  logic [PW-1:0]    lim;
  logic             in_range, hit;

  always_comb begin
    lim      = (PW'(tbl_used) > PW'(DEPTH)) ? PW'(DEPTH) : PW'(tbl_used);
    in_range = PW'(ptr_q) < lim;
    hit      = cmp_en & in_range & ~fired_q[ptr_q] & (mem[ptr_q] == count);
    if ((lim == '0) || (PW'(ptr_q) + 1'b1 >= lim)) ptr_d = '0;
    else                                            ptr_d = ptr_q + 1'b1;
    fired_d = fired_q;
    if (count_moved) fired_d = '0;
    else if (hit)    fired_d[ptr_q] = 1'b1;
    irq_d = hit;
    idx_d = hit ? ptr_q : idx_q;
  end

  always_ff @(posedge clk) begin
    if (tbl_we && (PW'(tbl_addr) < PW'(DEPTH))) mem[tbl_addr] <= tbl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      idx_q   <= '0;
      fired_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      fired_q <= fired_d;
      irq_q   <= irq_d;
    end
  end

  assign hit_irq = irq_q;
  assign hit_idx = idx_q;
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W       = 32,
  parameter int TBL_DEPTH   = 48,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(TBL_DEPTH),
  localparam int NUM_W      = $clog2(TBL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             quad_z,
  input  logic             scan_tick,
  input  logic             clr_req,
  input  logic             clr_mode,
  input  logic             cmp_en,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [CNT_W-1:0] tbl_data,
  input  logic [NUM_W-1:0] tbl_used,
  output logic [CNT_W-1:0] count,
  output logic             phase_err,
  output logic             hit_irq,
  output logic [IDX_W-1:0] hit_idx
);
  logic             srst_n;
  logic             step_up, step_dn, step_bad, z_rise;
  logic             clr_fire;
  logic [CNT_W-1:0] count_q, count_d;
  logic             err_q, err_d;
  logic             count_moved;

  qpc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  qpc_quad_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (srst_n),
    .a_in     (quad_a),
    .b_in     (quad_b),
    .z_in     (quad_z),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .step_bad (step_bad),
    .z_rise   (z_rise)
  );

  qpc_clear_ctrl u_clr (
    .clk       (clk),
    .rst_n     (srst_n),
    .scan_tick (scan_tick),
    .clr_req   (clr_req),
    .clr_mode  (clr_mode),
    .z_rise    (z_rise),
    .clr_fire  (clr_fire)
  );

  always_comb begin
    count_d = count_q;
    if (clr_fire)     count_d = '0;
    else if (step_up) count_d = count_q + 1'b1;
    else if (step_dn) count_d = count_q - 1'b1;
    err_d       = err_q | step_bad;
    count_moved = (count_d != count_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      err_q   <= err_d;
    end
  end

  qpc_target_cmp #(
    .CNT_W (CNT_W),
    .DEPTH (TBL_DEPTH),
    .IDX_W (IDX_W),
    .NUM_W (NUM_W)
  ) u_cmp (
    .clk         (clk),
    .rst_n       (srst_n),
    .count       (count_q),
    .count_moved (count_moved),
    .cmp_en      (cmp_en),
    .tbl_we      (tbl_we),
    .tbl_addr    (tbl_addr),
    .tbl_data    (tbl_data),
    .tbl_used    (tbl_used),
    .hit_irq     (hit_irq),
    .hit_idx     (hit_idx)
  );

  assign count     = count_q;
  assign phase_err = err_q;
endmodule

// File: rtl/qpc_chk.sv
module qpc_chk #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 6,
  parameter int NUM_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             phase_err,
  input logic             hit_irq,
  input logic [IDX_W-1:0] hit_idx,
  input logic [NUM_W-1:0] tbl_used,
  input logic             clr_fire
);
  // R3: the illegal-transition flag never drops outside reset
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> phase_err);

  // R7: a clear request taken at an edge leaves zero regardless of a step
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (count == '0));

  // R2: outside a clear the count moves by at most one per clock
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_fire) |-> ((count == $past(count)) ||
                          (count == $past(count) + 1'b1) ||
                          (count == $past(count) - 1'b1)));

  // R8: a reported entry lies inside the examined part of the table
  a_r8_idx_in_use: assert property (@(posedge clk) disable iff (!rst_n)
    hit_irq |-> (NUM_W'(hit_idx) < $past(tbl_used)));

  // R9: the same entry never pulses on two clocks in a row
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    hit_irq |=> !(hit_irq && (hit_idx == $past(hit_idx))));
endmodule

bind quad_pos_counter qpc_chk #(
  .CNT_W (CNT_W),
  .IDX_W (IDX_W),
  .NUM_W (NUM_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .count     (count),
  .phase_err (phase_err),
  .hit_irq   (hit_irq),
  .hit_idx   (hit_idx),
  .tbl_used  (tbl_used),
  .clr_fire  (clr_fire)
);

// File: tb/quad_pos_counter_tb_top.sv
`timescale 1ns/100ps
module quad_pos_counter_tb_top;
  localparam int CW  = 32;
  localparam int DEP = 48;
  localparam int IW  = 6;
  localparam int NW  = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          quad_a = 1'b0, quad_b = 1'b0, quad_z = 1'b0;
  logic          scan_tick = 1'b0, clr_req = 1'b0, clr_mode = 1'b0;
  logic          cmp_en = 1'b0, tbl_we = 1'b0;
  logic [IW-1:0] tbl_addr = '0;
  logic [CW-1:0] tbl_data = '0;
  logic [NW-1:0] tbl_used = '0;
  logic [CW-1:0] count;
  logic          phase_err, hit_irq;
  logic [IW-1:0] hit_idx;

  quad_pos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .quad_a(quad_a), .quad_b(quad_b), .quad_z(quad_z),
    .scan_tick(scan_tick), .clr_req(clr_req), .clr_mode(clr_mode), .cmp_en(cmp_en),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_used(tbl_used),
    .count(count), .phase_err(phase_err), .hit_irq(hit_irq), .hit_idx(hit_idx)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  int hits[$];
  logic [1:0] bpos = 2'd0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [CW-1:0] m_cnt;
  bit            m_err, m_irq, m_arm, mr1, mr2;
  int            m_idx, m_ptr;
  bit            m_fired[DEP];
  logic [CW-1:0] m_tbl[DEP];
  bit            ha[1:3], hb[1:3], hz[1:3];

  initial begin
    for (int i = 0; i < DEP; i++) begin m_tbl[i] = '0; m_fired[i] = 0; end
    m_cnt = '0; m_err = 0; m_irq = 0; m_arm = 0; mr1 = 0; mr2 = 0; m_idx = 0; m_ptr = 0;
    for (int i = 1; i <= 3; i++) begin ha[i] = 0; hb[i] = 0; hz[i] = 0; end
  end

  always @(posedge clk) begin
    int pn, po, d, lim;
    bit zr, fire, match;
    logic [CW-1:0] nc;
    if (!rst_n || !mr2) begin
      m_cnt = '0; m_err = 0; m_irq = 0; m_arm = 0; m_idx = 0; m_ptr = 0;
      for (int i = 0; i < DEP; i++) m_fired[i] = 0;
      for (int i = 1; i <= 3; i++) begin ha[i] = 0; hb[i] = 0; hz[i] = 0; end
      if (!rst_n) begin mr1 = 0; mr2 = 0; end
      else begin mr2 = mr1; mr1 = 1; end
    end else begin
      pn = {ha[2], ha[2] ^ hb[2]};
      po = {ha[3], ha[3] ^ hb[3]};
      d  = (pn - po) & 3;
      zr = hz[2] && !hz[3];
      fire = (scan_tick && clr_req && !clr_mode) || (clr_mode && m_arm && zr);
      if (fire)        nc = '0;
      else if (d == 1) nc = m_cnt + 1;
      else if (d == 3) nc = m_cnt - 1;
      else             nc = m_cnt;
      if (d == 2) m_err = 1;
      if (scan_tick)                     m_arm = clr_req && clr_mode;
      else if (clr_mode && m_arm && zr)  m_arm = 0;
      lim = (int'(tbl_used) > DEP) ? DEP : int'(tbl_used);
      match = cmp_en && (m_ptr < lim) && (m_tbl[m_ptr] == m_cnt) && !m_fired[m_ptr];
      m_irq = match;
      if (match) m_idx = m_ptr;
      if (nc != m_cnt) for (int i = 0; i < DEP; i++) m_fired[i] = 0;
      else if (match)  m_fired[m_ptr] = 1;
      m_ptr = (lim == 0 || m_ptr + 1 >= lim) ? 0 : m_ptr + 1;
      m_cnt = nc;
      ha[3] = ha[2]; ha[2] = ha[1]; ha[1] = quad_a;
      hb[3] = hb[2]; hb[2] = hb[1]; hb[1] = quad_b;
      hz[3] = hz[2]; hz[2] = hz[1]; hz[1] = quad_z;
    end
    if (tbl_we && int'(tbl_addr) < DEP) m_tbl[tbl_addr] = tbl_data;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(count == m_cnt && phase_err == m_err, "R2 model count/flag",
            longint'(count), longint'(m_cnt));
      check(hit_irq == m_irq && (!m_irq || int'(hit_idx) == m_idx), "R8 model irq",
            longint'({hit_irq, hit_idx}), longint'(m_irq) * 64 + m_idx);
    end
    if (hit_irq) hits.push_back(int'(hit_idx));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qmove(input int dir, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bpos   = bpos + 2'(dir);
      quad_a = bpos[1];
      quad_b = bpos[1] ^ bpos[0];
    end
  endtask

  task automatic scan_pulse(input bit req);
    @(negedge clk);
    scan_tick = 1'b1;
    clr_req   = req;
    @(negedge clk);
    scan_tick = 1'b0;
    clr_req   = 1'b0;
  endtask

  task automatic zpulse();
    @(negedge clk);
    quad_z = 1'b1;
    tick(3);
    quad_z = 1'b0;
    tick(5);
  endtask

  task automatic wr(input int addr, input logic [CW-1:0] val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = IW'(addr); tbl_data = val;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n  = 1'b1;
    cmp_on = 1'b1;
    tick(4);
    // R1 reset state
    check(count == 0 && !phase_err && !hit_irq, "R1 reset state", longint'(count), 0);

    // R2 counting both ways
    qmove(1, 8); tick(4);
    check(count == 8, "R2 forward steps", longint'(count), 8);
    qmove(-1, 3); tick(4);
    check(count == 5, "R2 backward steps", longint'(count), 5);
    qmove(1, 1); tick(2);
    check(count == 5, "R2 latency before third edge", longint'(count), 5);
    tick(1);
    check(count == 6, "R2 latency at third edge", longint'(count), 6);

    // R3 illegal jump
    @(negedge clk);
    bpos = bpos + 2'd2; quad_a = bpos[1]; quad_b = bpos[1] ^ bpos[0];
    tick(4);
    check(count == 6, "R3 illegal jump keeps count", longint'(count), 6);
    check(phase_err == 1'b1, "R3 flag set", longint'(phase_err), 1);
    qmove(1, 2); tick(4);
    check(phase_err == 1'b1 && count == 8, "R3 flag sticky", longint'(phase_err), 1);

    // R4 direct clear
    clr_mode = 1'b0; clr_req = 1'b1; tick(3); clr_req = 1'b0; tick(2);
    check(count == 8, "R4 request without strobe ignored", longint'(count), 8);
    scan_pulse(1'b1);
    check(count == 0, "R4 strobe clears", longint'(count), 0);

    // R5 index clear
    qmove(1, 3); tick(4);
    clr_mode = 1'b1;
    scan_pulse(1'b1); tick(4);
    check(count == 3, "R5 armed waits for index", longint'(count), 3);
    zpulse();
    check(count == 0, "R5 index edge clears", longint'(count), 0);
    qmove(1, 2); tick(4);
    zpulse();
    check(count == 2, "R5 second index edge no clear", longint'(count), 2);

    // R6 unarmed and disarmed
    zpulse();
    check(count == 2, "R6 unarmed index ignored", longint'(count), 2);
    scan_pulse(1'b1);
    scan_pulse(1'b0);
    zpulse();
    check(count == 2, "R6 disarmed by low sample", longint'(count), 2);

    // R7 clear and step on the same edge
    clr_mode = 1'b0;
    qmove(1, 1); tick(1);
    scan_pulse(1'b1);
    check(count == 0, "R7 clear wins", longint'(count), 0);
    tick(4);
    check(count == 0, "R7 step dropped", longint'(count), 0);

    // R8 / R9 table matching
    for (int i = 0; i < DEP; i++) wr(i, CW'(1000 + i));
    wr(1, 7); wr(5, 7); wr(47, 3);
    tbl_used = NW'(2); cmp_en = 1'b1; tick(2);
    qmove(1, 7); tick(60);
    check(hits.size() == 1 && hits[0] == 1, "R8 hit on entry 1", hits.size(), 1);
    tick(60);
    check(hits.size() == 1, "R9 no repeat while count holds", hits.size(), 1);
    tbl_used = NW'(48); tick(120);
    check(hits.size() == 2 && hits[1] == 5, "R8 wider window finds entry 5", hits.size(), 2);
    qmove(-1, 4); tick(120);
    check(hits.size() == 3 && hits[2] == 47, "R8 last entry hit", hits.size(), 3);

    // R11 compare disabled
    cmp_en = 1'b0;
    qmove(1, 4); tick(120);
    check(hits.size() == 3, "R11 no hit while disabled", hits.size(), 3);
    qmove(1, 1); tick(4);
    cmp_en = 1'b1; tick(120);
    check(hits.size() == 3, "R11 enable at non-matching count", hits.size(), 3);

    // R10 clear leaves table and enable
    wr(47, CW'(1047)); wr(2, 0);
    scan_pulse(1'b1);
    check(count == 0, "R10 cleared", longint'(count), 0);
    tick(120);
    check(hits.size() == 4 && hits[3] == 2, "R10 zero entry hits after clear", hits.size(), 4);
    qmove(1, 7); tick(120);
    check(hits.size() == 6 && ((hits[4] == 1 && hits[5] == 5) || (hits[4] == 5 && hits[5] == 1)),
          "R10 old entries kept", hits.size(), 6);

    cmp_on = 1'b0;
    summary();
    $finish;
  end
endmodule